// File: doc/BRIEF.md
# Fixed-Point to Single-Precision Float Converter

This block takes a signed-magnitude fixed-point number, made of a sign flag, an integer part and a fractional part, and turns it into a 32-bit binary floating-point word. The word has a sign bit, an 8-bit biased exponent and a 23-bit fraction. A caller presents the operand together with a one-cycle `start` strobe while `busy` is low. The block then normalizes the magnitude one position per clock. Each step to the right raises the working exponent by one, and each step to the left lowers it by one. Stepping stops when the only set bit above the binary point is the one directly left of it. The exponent is then biased, the leading one is discarded, and the fields are packed.

The result is raised together with a one-cycle `done` pulse. It stays on `result` until the next conversion completes. Bits that fall below the fraction field are simply dropped. A magnitude of zero yields the all-zero word, whatever the sign. Denormal results cannot arise for the default widths, because the smallest nonzero input, 2^-16, is far above the normal range floor.

Top module: `fx2f_conv`

## Requirements
- R1: `result` bit 31 holds the sign, bits 30..23 hold the biased exponent and bits 22..0 hold the fraction field.
- R2: For a nonzero magnitude, `in_sign`=1 gives `result[31]`=1 (negative) and `in_sign`=0 gives `result[31]`=0.
- R3: The exponent field equals floor(log2(magnitude)) + 127. The magnitude is `in_int` + `in_frac`/65536, so 2^-16 gives 0x6F and 2^15 gives 0x8E.
- R4: The leading one is not stored. The fraction field holds the magnitude bits that follow that leading one, MSB first, padded with zeros on the right (1.0 gives 0x3F800000 and 0.5 gives 0x3F000000).
- R5: Sign 1, integer 28 and fraction 0xC000 (-28.75) give 0xC1E60000.
- R6: A zero magnitude gives `result` = 0x00000000 for either sign.
- R7: Magnitude bits below the fraction field are discarded without rounding, so integer 0xFFFF with fraction 0xFFFF gives 0x477FFFFF.
- R8: `busy` goes high in the cycle after an accepted `start` and stays high until the conversion ends. A `start` seen while `busy` is high is ignored and produces no result.
- R9: `done` is high for exactly one cycle per accepted `start`, in the cycle that the new word first appears on `result`. `result` does not change in any other cycle.
- R10: `done` comes no later than INT_W+FRAC_W+2 cycles after the accepting edge. That edge is followed by one load cycle and at most 32 shift cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a conversion; taken only while `busy` is low |
| in_sign | input | 1 | Operand sign, 1 = negative |
| in_int | input | INT_W (16) | Integer part of the magnitude |
| in_frac | input | FRAC_W (16) | Fractional part of the magnitude |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse: `result` carries a new word |
| result | output | 1+EXP_W+MAN_W (32) | Packed floating-point word |

## Verification
Delivery of a finished word and acceptance of the next operand can land in the same cycle. `busy` falls on the same edge that raises `done`, so a `start` held in that cycle must be taken. The bench's driver presents each new operand at the first low `busy` it sees, which is exactly the `done` cycle. The scoreboard then expects both words in order, each exactly once. A second case holds `start` with a different operand during the shift loop. In that case only the first operand's word may emerge, and an extra `done` counts as a failure.

// File: rtl/fx2f_pkg.sv
package fx2f_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } conv_state_e;

   typedef enum logic [1:0] {
      MV_RIGHT = 2'd0,
      MV_LEFT  = 2'd1,
      MV_DONE  = 2'd2
   } norm_move_e;

endpackage

// File: rtl/fx2f_align.sv
module fx2f_align #(
   parameter int INT_W  = 16,
   parameter int FRAC_W = 16,
   parameter int MAN_W  = 23,
   localparam int WK    = INT_W + MAN_W
) (
   input  logic [INT_W-1:0]  in_int,
   input  logic [FRAC_W-1:0] in_frac,
   output logic [WK-1:0]     work
);

   // Working register: binary point sits just above bit MAN_W-1.
   if (MAN_W == FRAC_W) begin : g_exact
      assign work = {in_int, in_frac};
   end else begin : g_pad
      assign work = {in_int, in_frac, {(MAN_W-FRAC_W){1'b0}}};
   end

endmodule

// File: rtl/fx2f_step.sv
module fx2f_step
   import fx2f_pkg::*;
#(
   parameter int WK    = 39,
   parameter int MAN_W = 23
) (
   input  logic [WK-1:0] work,
   output norm_move_e    move,
   output logic [WK-1:0] work_nxt,
   output logic          is_zero
);

   always_comb begin
      is_zero  = (work == '0);
      work_nxt = work;
      if (|work[WK-1:MAN_W+1]) begin
         move     = MV_RIGHT;
         work_nxt = work >> 1;
      end else if (work[MAN_W] || is_zero) begin
         move     = MV_DONE;
      end else begin
         move     = MV_LEFT;
         work_nxt = work << 1;
      end
   end

endmodule

// File: rtl/fx2f_pack.sv
module fx2f_pack #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   parameter int EC_W  = 9,
   parameter int BIAS  = 127
) (
   input  logic                   sign,
   input  logic                   is_zero,
   input  logic [EC_W-1:0]        exp_true,
   input  logic [MAN_W-1:0]       frac,
   output logic [EXP_W+MAN_W:0]   word
);

   logic [EC_W-1:0] biased;

   // Two's-complement exponent plus bias; the sum is positive and fits EXP_W.
   assign biased = exp_true + EC_W'(BIAS);

   always_comb begin
      if (is_zero) word = '0;
      else         word = {sign, biased[EXP_W-1:0], frac};
   end

endmodule

// File: rtl/fx2f_conv.sv
module fx2f_conv
   import fx2f_pkg::*;
#(
   parameter int INT_W  = 16,
   parameter int FRAC_W = 16,
   parameter int EXP_W  = 8,
   parameter int MAN_W  = 23,
   localparam int OUT_W = 1 + EXP_W + MAN_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              in_sign,
   input  logic [INT_W-1:0]  in_int,
   input  logic [FRAC_W-1:0] in_frac,
   output logic              busy,
   output logic              done,
   output logic [OUT_W-1:0]  result
);

   localparam int WK      = INT_W + MAN_W;
   localparam int BIAS    = (1 << (EXP_W-1)) - 1;
   localparam int EC_W    = EXP_W + 1;
   localparam int MAX_LAT = INT_W + FRAC_W + 1;
   localparam int CNT_W   = $clog2(MAX_LAT + 3);

   if (MAN_W < FRAC_W) begin : g_chk_man
      $error("fx2f_conv: MAN_W must be at least FRAC_W");
   end
   if (INT_W < 2) begin : g_chk_int
      $error("fx2f_conv: INT_W must be at least 2");
   end
   if (INT_W - 1 > BIAS || FRAC_W > BIAS - 1) begin : g_chk_range
      $error("fx2f_conv: operand range exceeds normal exponent range");
   end

   conv_state_e      state_q;
   logic [WK-1:0]    work_q;
   logic [EC_W-1:0]  exp_q;
   logic             sign_q;
   logic [OUT_W-1:0] result_q;
   logic             done_q;
   logic [CNT_W-1:0] cyc_q;

   logic [WK-1:0]    work_load;
   logic [WK-1:0]    work_nxt;
   norm_move_e       move;
   logic             is_zero;
   logic [OUT_W-1:0] packed_word;

   fx2f_align #(
      .INT_W (INT_W),
      .FRAC_W(FRAC_W),
      .MAN_W (MAN_W)
   ) i_align (
      .in_int (in_int),
      .in_frac(in_frac),
      .work   (work_load)
   );

   fx2f_step #(
      .WK   (WK),
      .MAN_W(MAN_W)
   ) i_step (
      .work    (work_q),
      .move    (move),
      .work_nxt(work_nxt),
      .is_zero (is_zero)
   );

   fx2f_pack #(
      .EXP_W(EXP_W),
      .MAN_W(MAN_W),
      .EC_W (EC_W),
      .BIAS (BIAS)
   ) i_pack (
      .sign    (sign_q),
      .is_zero (is_zero),
      .exp_true(exp_q),
      .frac    (work_q[MAN_W-1:0]),
      .word    (packed_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         work_q   <= '0;
         exp_q    <= '0;
         sign_q   <= 1'b0;
         result_q <= '0;
         done_q   <= 1'b0;
         cyc_q    <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  work_q  <= work_load;
                  exp_q   <= '0;
                  sign_q  <= in_sign;
                  cyc_q   <= '0;
                  state_q <= ST_RUN;
               end
            end
            ST_RUN: begin
               cyc_q <= cyc_q + CNT_W'(1);
               unique case (move)
                  MV_RIGHT: begin
                     work_q <= work_nxt;
                     exp_q  <= exp_q + EC_W'(1);
                  end
                  MV_LEFT: begin
                     work_q <= work_nxt;
                     exp_q  <= exp_q - EC_W'(1);
                  end
                  default: begin
                     result_q <= packed_word;
                     done_q   <= 1'b1;
                     state_q  <= ST_IDLE;
                  end
               endcase
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy   = (state_q == ST_RUN);
   assign done   = done_q;
   assign result = result_q;

   // ---------------- assertions ----------------
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   assert_sign_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(sign_q));

   assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> (done || $stable(result)));

   assert_zero_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && result[OUT_W-2:MAN_W] == '0) |-> (result == '0));

   assert_exp_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && result != '0) |->
         (int'(result[OUT_W-2:MAN_W]) >= BIAS - FRAC_W &&
          int'(result[OUT_W-2:MAN_W]) <= BIAS + INT_W - 1));

   assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (int'(cyc_q) <= MAX_LAT));

endmodule

// File: tb/test_fx2f_conv.sv
module test_fx2f_conv;

   localparam int CLK_PERIOD = 10;
   localparam int INT_W  = 16;
   localparam int FRAC_W = 16;
   localparam int LAT_MAX = INT_W + FRAC_W + 2;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              start;
   logic              in_sign;
   logic [INT_W-1:0]  in_int;
   logic [FRAC_W-1:0] in_frac;
   logic              busy;
   logic              done;
   logic [31:0]       result;

   always #(CLK_PERIOD/2) clk = ~clk;

   fx2f_conv i_fx2f_conv (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .in_sign(in_sign),
      .in_int (in_int),
      .in_frac(in_frac),
      .busy   (busy),
      .done   (done),
      .result (result)
   );

   int     checks = 0;
   int     errors = 0;
   longint cyc    = 0;
   always @(posedge clk) cyc <= cyc + 1;

   logic [31:0] sb_word[$];
   string       sb_tag[$];
   longint      sb_stamp[$];

   task automatic check(input bit ok, input string tag,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Reference from plain integer arithmetic on the 32-bit magnitude.
   function automatic logic [31:0] ref_word(input logic s, input logic [15:0] ip,
                                            input logic [15:0] fp);
      logic [31:0] mag;
      logic [31:0] man;
      int          p;
      mag = {ip, fp};
      if (mag == 0) return 32'h0;
      p = 0;
      for (int k = 0; k < 32; k++) if (mag[k]) p = k;
      if (p >= 23) man = mag >> (p - 23);
      else         man = mag << (23 - p);
      return {s, 8'(p - 16 + 127), man[22:0]};
   endfunction

   task automatic convert(input logic s, input logic [15:0] ip, input logic [15:0] fp,
                          input logic [31:0] exp_word, input string tag);
      while (busy) @(negedge clk);
      in_sign = s;
      in_int  = ip;
      in_frac = fp;
      start   = 1'b1;
      sb_word.push_back(exp_word);
      sb_tag.push_back(tag);
      sb_stamp.push_back(cyc);
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R8 busy after start", 32'(busy), 32'd1);
   endtask

   // Monitor / scoreboard
   logic [31:0] prev_result;
   logic        prev_done;
   bit          have_prev = 0;
   always @(negedge clk) begin
      if (rst_n === 1'b1) begin
         if (done) begin
            if (prev_done) check(1'b0, "R9 done longer than one cycle", 32'd1, 32'd0);
            if (sb_word.size() == 0) begin
               check(1'b0, "R9 unexpected done", result, 32'h0);
            end else begin
               logic [31:0] w;
               string       t;
               longint      st;
               w  = sb_word.pop_front();
               t  = sb_tag.pop_front();
               st = sb_stamp.pop_front();
               check(result === w, t, result, w);
               check((cyc - st) <= LAT_MAX, "R10 latency", 32'(cyc - st), 32'(LAT_MAX));
            end
         end else if (have_prev && result !== prev_result) begin
            check(1'b0, "R9 result changed without done", result, prev_result);
         end
         prev_result = result;
         prev_done   = done;
         have_prev   = 1;
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] lfsr;
      rst_n   = 1'b0;
      start   = 1'b0;
      in_sign = 1'b0;
      in_int  = '0;
      in_frac = '0;
      repeat (3) @(negedge clk);
      check(busy == 1'b0, "reset busy", 32'(busy), 32'd0);
      check(done == 1'b0, "reset done", 32'(done), 32'd0);
      check(result == 32'h0, "reset result", result, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      convert(1'b1, 16'd28,     16'hC000, 32'hC1E60000, "R5 -28.75");
      convert(1'b0, 16'd1,      16'h0000, 32'h3F800000, "R4 one");
      convert(1'b0, 16'd0,      16'h8000, 32'h3F000000, "R4 half");
      convert(1'b1, 16'd1,      16'h8000, 32'hBFC00000, "R2 negative -1.5");
      convert(1'b0, 16'd0,      16'h0000, 32'h00000000, "R6 positive zero");
      convert(1'b1, 16'd0,      16'h0000, 32'h00000000, "R6 negative zero");
      convert(1'b0, 16'd0,      16'h0001, 32'h37800000, "R3 smallest");
      convert(1'b0, 16'h8000,   16'h0000, 32'h47000000, "R3 largest power");
      convert(1'b0, 16'hFFFF,   16'hFFFF, 32'h477FFFFF, "R7 truncation");

      // Start held during a long conversion must be ignored (R8).
      convert(1'b1, 16'd0, 16'h0001, 32'hB7800000, "R8 first of ignored pair");
      in_sign = 1'b0;
      in_int  = 16'h1234;
      in_frac = 16'h5678;
      start   = 1'b1;
      @(negedge clk);
      check(busy == 1'b1, "R8 busy while start ignored", 32'(busy), 32'd1);
      @(negedge clk);
      check(busy == 1'b1, "R8 busy while start ignored", 32'(busy), 32'd1);
      start = 1'b0;

      // Back-to-back pseudo-random operands through the field layout (R1).
      lfsr = 32'hACE1_2468;
      for (int n = 0; n < 24; n++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         convert(lfsr[7], lfsr[31:16] >> (n % 16), lfsr[15:0],
                 ref_word(lfsr[7], lfsr[31:16] >> (n % 16), lfsr[15:0]), "R1 pattern");
      end

      for (int w = 0; w < 200 && sb_word.size() != 0; w++) @(negedge clk);
      repeat (3) @(negedge clk);
      if (sb_word.size() != 0) check(1'b0, "R9 missing done", 32'(sb_word.size()), 32'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule